// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. The datapath uses one shared memory, one ALU and a few internal latches. The sequencer splits each instruction into a chain of one-cycle steps. Every step does at most one ALU operation, one register-file access or one memory access.

Every instruction starts with the same two steps, fetch and then decode. After decode the sequencer branches on the opcode held in the instruction register. It drives the datapath's write strobes, multiplexer selects and ALU operation code in each step. The result is that loads take five cycles, stores and register-register operations take four, and branches and jumps take three. A small ALU decoder inside the block turns the R-type function field into the 3-bit operation that the ALU executes.

The surrounding datapath holds the instruction register. It presents `opcode` and `funct` from that register and returns the ALU zero flag. The sequencer reads these inputs and steers the datapath.

Top module: `mcc_control`

## Requirements
- R1: While the synchronous reset `rst` is high, every output is 0, including all write strobes and `pc_load`. The cycle that follows the release of reset is a fetch cycle.
- R2: A fetch cycle asserts `mem_rd`, `ir_wr` and `pc_wr`, with `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=010 (add) and `pc_src`=0 (live ALU result).
- R3: A fetch cycle is always followed by a decode cycle. Decode asserts no write strobe and drives `alu_a_sel`=0, `alu_b_sel`=3 (shifted immediate) and `alu_op`=010.
- R4: A load (opcode 100011) runs five cycles: fetch, decode, address, read, write-back.
  - Address: `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended immediate), `alu_op`=010.
  - Read: `mem_rd` with `addr_sel`=1 (ALU latch).
  - Write-back: `reg_wr` with `reg_dst`=0 (rt) and `mem_to_reg`=1 (memory data register).
- R5: A store (opcode 101011) runs four cycles: fetch, decode, the same address step as a load, then `mem_wr` with `addr_sel`=1. `mem_rd` and `mem_wr` are never high together.
- R6: An R-type instruction (opcode 000000) runs four cycles: fetch, decode, execute, completion.
  - Execute: `alu_a_sel`=1, `alu_b_sel`=0 (register B), `alu_op` taken from `funct`.
  - Completion: `reg_wr` with `reg_dst`=1 (rd) and `mem_to_reg`=0 (ALU latch).
- R7: In R-type execute, `alu_op` maps from `funct` as follows: 100000→010, 100010→011, 100100→000, 100101→001, 101010→111. Any other `funct` gives 010.
- R8: A branch-on-equal (opcode 000100) runs three cycles. Its third cycle drives `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=011 (compare), `pc_src`=1 (ALU latch) and `pc_wr_cond`.
- R9: A jump (opcode 000010) runs three cycles. Its third cycle asserts `pc_wr` with `pc_src`=2 (jump target).
- R10: Any other opcode returns to fetch directly after decode, so the third cycle is a fetch. No write strobe is asserted in between.
- R11: In every cycle, each select and `alu_op` field that the step does not use is 0, and each strobe not listed for the step is 0.
- R12: `pc_load` is high exactly when `pc_wr` is high, or when `pc_wr_cond` and `zero` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| funct | input | FN_W | Function field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if zero flag set |
| pc_load | output | 1 | Combined PC load enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU latch |
| reg_dst | output | 1 | Write register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALU latch, 1 memory data register |
| alu_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B: 0 reg B, 1 four, 2 immediate, 3 shifted immediate |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALU latch, 2 jump target |
| alu_op | output | 3 | ALU operation code |

## Verification
The bench targets the cycle counts of each instruction class. A sequencer that took one step too many or too few would show a non-fetch word where the next fetch is expected.

Undefined opcodes and undefined function codes are both exercised. A design that fell through to some class's steps would raise a strobe, and one that passed `funct` through raw would emit the wrong `alu_op`.

Branches run with `zero` both set and clear, so a PC load that ignores the flag is exposed. Reset is also asserted in the middle of a load, so any strobe that leaks during reset, or any wrong restart state, is caught.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int ALU_OP_W = 3;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_LD_ADDR,
        S_LD_READ,
        S_LD_WB,
        S_ST_ADDR,
        S_ST_WRITE,
        S_R_EXEC,
        S_R_WB,
        S_BR_CMP,
        S_JUMP
    } state_e;

    typedef enum logic [2:0] {
        K_RTYPE,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_JUMP,
        K_BAD
    } iclass_e;

    typedef enum logic [1:0] {
        AK_NONE,
        AK_ADD,
        AK_CMP,
        AK_FUNCT
    } alu_kind_e;

    // ALU operand B selections
    localparam logic [1:0] B_REGB   = 2'd0;
    localparam logic [1:0] B_FOUR   = 2'd1;
    localparam logic [1:0] B_IMM    = 2'd2;
    localparam logic [1:0] B_IMM_SH = 2'd3;

    // PC source selections
    localparam logic [1:0] PCS_ALU   = 2'd0;
    localparam logic [1:0] PCS_LATCH = 2'd1;
    localparam logic [1:0] PCS_JUMP  = 2'd2;

    // ALU operation codes
    localparam logic [ALU_OP_W-1:0] OP_AND = 3'b000;
    localparam logic [ALU_OP_W-1:0] OP_OR  = 3'b001;
    localparam logic [ALU_OP_W-1:0] OP_ADD = 3'b010;
    localparam logic [ALU_OP_W-1:0] OP_SUB = 3'b011;
    localparam logic [ALU_OP_W-1:0] OP_SLT = 3'b111;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       reg_wr;
        logic       addr_sel;
        logic       reg_dst;
        logic       mem_to_reg;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] pc_src;
        alu_kind_e  alu_kind;
    } ctl_t;

    typedef struct packed {
        state_e state;
    } seq_regs_t;

endpackage

// File: rtl/mcc_op_classify.sv
module mcc_op_classify
    import mcc_pkg::*;
#(
    parameter int                OPC_W      = 6,
    parameter logic [OPC_W-1:0]  OPC_RTYPE  = 6'b000000,
    parameter logic [OPC_W-1:0]  OPC_LOAD   = 6'b100011,
    parameter logic [OPC_W-1:0]  OPC_STORE  = 6'b101011,
    parameter logic [OPC_W-1:0]  OPC_BRANCH = 6'b000100,
    parameter logic [OPC_W-1:0]  OPC_JUMP   = 6'b000010
) (
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          cls
);

    always_comb begin
        if (opcode == OPC_RTYPE)       cls = K_RTYPE;
        else if (opcode == OPC_LOAD)   cls = K_LOAD;
        else if (opcode == OPC_STORE)  cls = K_STORE;
        else if (opcode == OPC_BRANCH) cls = K_BRANCH;
        else if (opcode == OPC_JUMP)   cls = K_JUMP;
        else                           cls = K_BAD;
    end

endmodule

// File: rtl/mcc_out_decode.sv
module mcc_out_decode
    import mcc_pkg::*;
(
    input  state_e st,
    output ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        unique case (st)
            S_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.pc_wr     = 1'b1;
                ctl.alu_b_sel = B_FOUR;
                ctl.pc_src    = PCS_ALU;
                ctl.alu_kind  = AK_ADD;
            end
            S_DECODE: begin
                ctl.alu_b_sel = B_IMM_SH;
                ctl.alu_kind  = AK_ADD;
            end
            S_LD_ADDR, S_ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = B_IMM;
                ctl.alu_kind  = AK_ADD;
            end
            S_LD_READ: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_LD_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            S_ST_WRITE: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_R_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = B_REGB;
                ctl.alu_kind  = AK_FUNCT;
            end
            S_R_WB: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            S_BR_CMP: begin
                ctl.pc_wr_cond = 1'b1;
                ctl.alu_a_sel  = 1'b1;
                ctl.alu_b_sel  = B_REGB;
                ctl.alu_kind   = AK_CMP;
                ctl.pc_src     = PCS_LATCH;
            end
            S_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mcc_alu_decoder.sv
module mcc_alu_decoder
    import mcc_pkg::*;
#(
    parameter int               FN_W   = 6,
    parameter logic [FN_W-1:0]  FN_ADD = 6'b100000,
    parameter logic [FN_W-1:0]  FN_SUB = 6'b100010,
    parameter logic [FN_W-1:0]  FN_AND = 6'b100100,
    parameter logic [FN_W-1:0]  FN_OR  = 6'b100101,
    parameter logic [FN_W-1:0]  FN_SLT = 6'b101010
) (
    input  alu_kind_e           kind,
    input  logic [FN_W-1:0]     funct,
    output logic [ALU_OP_W-1:0] op
);

    logic [ALU_OP_W-1:0] fn_op;

    always_comb begin
        if (funct == FN_SUB)      fn_op = OP_SUB;
        else if (funct == FN_AND) fn_op = OP_AND;
        else if (funct == FN_OR)  fn_op = OP_OR;
        else if (funct == FN_SLT) fn_op = OP_SLT;
        else if (funct == FN_ADD) fn_op = OP_ADD;
        else                      fn_op = OP_ADD;
    end

    always_comb begin
        unique case (kind)
            AK_ADD:   op = OP_ADD;
            AK_CMP:   op = OP_SUB;
            AK_FUNCT: op = fn_op;
            default:  op = '0;
        endcase
    end

endmodule

// File: rtl/mcc_control.sv
module mcc_control
    import mcc_pkg::*;
#(
    parameter int               OPC_W      = 6,
    parameter int               FN_W       = 6,
    parameter logic [OPC_W-1:0] OPC_RTYPE  = 6'b000000,
    parameter logic [OPC_W-1:0] OPC_LOAD   = 6'b100011,
    parameter logic [OPC_W-1:0] OPC_STORE  = 6'b101011,
    parameter logic [OPC_W-1:0] OPC_BRANCH = 6'b000100,
    parameter logic [OPC_W-1:0] OPC_JUMP   = 6'b000010
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FN_W-1:0]    funct,
    input  logic               zero,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               pc_load,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               ir_wr,
    output logic               reg_wr,
    output logic               addr_sel,
    output logic               reg_dst,
    output logic               mem_to_reg,
    output logic               alu_a_sel,
    output logic [1:0]         alu_b_sel,
    output logic [1:0]         pc_src,
    output logic [2:0]         alu_op
);

    localparam seq_regs_t RESET_VAL = '{state: S_FETCH};

    seq_regs_t regs_d, regs_q;
    iclass_e   cls;
    ctl_t      ctl_raw;
    ctl_t      ctl_eff;

    mcc_op_classify #(
        .OPC_W      (OPC_W),
        .OPC_RTYPE  (OPC_RTYPE),
        .OPC_LOAD   (OPC_LOAD),
        .OPC_STORE  (OPC_STORE),
        .OPC_BRANCH (OPC_BRANCH),
        .OPC_JUMP   (OPC_JUMP)
    ) u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    // Next-state process: class is resolved once, at decode.
    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            S_FETCH: regs_d.state = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    K_RTYPE:  regs_d.state = S_R_EXEC;
                    K_LOAD:   regs_d.state = S_LD_ADDR;
                    K_STORE:  regs_d.state = S_ST_ADDR;
                    K_BRANCH: regs_d.state = S_BR_CMP;
                    K_JUMP:   regs_d.state = S_JUMP;
                    default:  regs_d.state = S_FETCH;
                endcase
            end
            S_LD_ADDR:  regs_d.state = S_LD_READ;
            S_LD_READ:  regs_d.state = S_LD_WB;
            S_ST_ADDR:  regs_d.state = S_ST_WRITE;
            S_R_EXEC:   regs_d.state = S_R_WB;
            S_LD_WB, S_ST_WRITE, S_R_WB, S_BR_CMP, S_JUMP:
                        regs_d.state = S_FETCH;
            default:    regs_d.state = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= RESET_VAL;
        else     regs_q <= regs_d;
    end

    mcc_out_decode u_out (
        .st  (regs_q.state),
        .ctl (ctl_raw)
    );

    // Reset silences the whole control word.
    assign ctl_eff = rst ? '0 : ctl_raw;

    mcc_alu_decoder #(
        .FN_W (FN_W)
    ) u_alu_dec (
        .kind  (ctl_eff.alu_kind),
        .funct (funct),
        .op    (alu_op)
    );

    assign pc_wr      = ctl_eff.pc_wr;
    assign pc_wr_cond = ctl_eff.pc_wr_cond;
    assign pc_load    = ctl_eff.pc_wr | (ctl_eff.pc_wr_cond & zero);
    assign mem_rd     = ctl_eff.mem_rd;
    assign mem_wr     = ctl_eff.mem_wr;
    assign ir_wr      = ctl_eff.ir_wr;
    assign reg_wr     = ctl_eff.reg_wr;
    assign addr_sel   = ctl_eff.addr_sel;
    assign reg_dst    = ctl_eff.reg_dst;
    assign mem_to_reg = ctl_eff.mem_to_reg;
    assign alu_a_sel  = ctl_eff.alu_a_sel;
    assign alu_b_sel  = ctl_eff.alu_b_sel;
    assign pc_src     = ctl_eff.pc_src;

endmodule

// File: rtl/mcc_control_chk.sv
module mcc_control_chk (
    input logic       clk,
    input logic       rst,
    input logic       zero,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_load,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_wr,
    input logic       reg_wr,
    input logic       addr_sel,
    input logic       reg_dst,
    input logic       mem_to_reg,
    input logic       alu_a_sel,
    input logic [1:0] alu_b_sel,
    input logic [1:0] pc_src
);

    logic any_wr;
    assign any_wr = pc_wr | pc_wr_cond | mem_rd | mem_wr | ir_wr | reg_wr;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (!any_wr && !pc_load));

    a_r2_fetch_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_wr && mem_rd && pc_wr));

    a_r3_decode_quiet: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> !any_wr);

    a_r4_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && mem_to_reg) |-> $past(mem_rd && addr_sel));

    a_r5_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r5_store_returns: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    a_r6_wb_after_exec: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_dst) |-> $past(alu_a_sel && alu_b_sel == 2'd0 && !pc_wr_cond));

    a_r8_cond_needs_zero: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !zero) |-> !pc_load);

    a_r9_jump_returns: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == 2'd2) |=> ir_wr);

endmodule

bind mcc_control mcc_control_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .zero       (zero),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_load    (pc_load),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_wr      (ir_wr),
    .reg_wr     (reg_wr),
    .addr_sel   (addr_sel),
    .reg_dst    (reg_dst),
    .mem_to_reg (mem_to_reg),
    .alu_a_sel  (alu_a_sel),
    .alu_b_sel  (alu_b_sel),
    .pc_src     (pc_src)
);

// File: tb/mcc_control_test.sv
`timescale 1ns/1ps
module mcc_control_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;
    logic       pc_wr, pc_wr_cond, pc_load, mem_rd, mem_wr, ir_wr, reg_wr;
    logic       addr_sel, reg_dst, mem_to_reg, alu_a_sel;
    logic [1:0] alu_b_sel, pc_src;
    logic [2:0] alu_op;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mcc_control uut (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_load(pc_load),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .addr_sel(addr_sel), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .pc_src(pc_src),
        .alu_op(alu_op)
    );

    // Instruction classes used by the model
    localparam int C_R = 0, C_LW = 1, C_SW = 2, C_BEQ = 3, C_J = 4, C_BAD = 5;

    function automatic int class_len(int c);
        case (c)
            C_LW:          return 5;
            C_SW, C_R:     return 4;
            C_BEQ, C_J:    return 3;
            default:       return 2;
        endcase
    endfunction

    function automatic logic [5:0] class_opc(int c);
        case (c)
            C_R:   return 6'b000000;
            C_LW:  return 6'b100011;
            C_SW:  return 6'b101011;
            C_BEQ: return 6'b000100;
            C_J:   return 6'b000010;
            default: return 6'b111111;
        endcase
    endfunction

    // R7 function-field mapping
    function automatic logic [2:0] fn_map(logic [5:0] f);
        case (f)
            6'h20: return 3'b010;
            6'h22: return 3'b011;
            6'h24: return 3'b000;
            6'h25: return 3'b001;
            6'h2A: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    function automatic string req_of(int c, int s);
        if (s == 0) return "R2";
        if (s == 1) return "R3";
        case (c)
            C_LW:  return "R4";
            C_SW:  return "R5";
            C_R:   return (s == 2) ? "R7" : "R6";
            C_BEQ: return "R8";
            C_J:   return "R9";
            default: return "R10";
        endcase
    endfunction

    // Expected control word; every field not set stays 0 (R11)
    function automatic logic [17:0] expect_word(int c, int s, logic [5:0] f, logic z);
        logic pw = 0, pwc = 0, mr = 0, mw = 0, iw = 0, rw = 0;
        logic asel = 0, rd = 0, m2r = 0, asrc = 0;
        logic [1:0] bsrc = 0, psrc = 0;
        logic [2:0] op = 0;
        if (s == 0) begin
            pw = 1; mr = 1; iw = 1; bsrc = 1; op = 3'b010;
        end else if (s == 1) begin
            bsrc = 3; op = 3'b010;
        end else begin
            case (c)
                C_LW: begin
                    if (s == 2) begin asrc = 1; bsrc = 2; op = 3'b010; end
                    if (s == 3) begin mr = 1; asel = 1; end
                    if (s == 4) begin rw = 1; m2r = 1; end
                end
                C_SW: begin
                    if (s == 2) begin asrc = 1; bsrc = 2; op = 3'b010; end
                    if (s == 3) begin mw = 1; asel = 1; end
                end
                C_R: begin
                    if (s == 2) begin asrc = 1; op = fn_map(f); end
                    if (s == 3) begin rw = 1; rd = 1; end
                end
                C_BEQ: begin
                    pwc = 1; asrc = 1; op = 3'b011; psrc = 1;
                end
                C_J: begin
                    pw = 1; psrc = 2;
                end
                default: ;
            endcase
        end
        return {pw, pwc, pw | (pwc & z), mr, mw, iw, rw, asel, rd, m2r, asrc, bsrc, psrc, op};
    endfunction

    function automatic logic [17:0] got_word();
        return {pc_wr, pc_wr_cond, pc_load, mem_rd, mem_wr, ir_wr, reg_wr, addr_sel,
                reg_dst, mem_to_reg, alu_a_sel, alu_b_sel, pc_src, alu_op};
    endfunction

    task automatic check_word(string req, logic [17:0] exp_w);
        logic [17:0] g;
        g = got_word();
        tests++;
        if (g !== exp_w) begin
            fails++;
            $display("FAIL %s: actual %05h expected %05h", req, g, exp_w);
        end
    endtask

    // Runs nsteps cycles of an instruction starting at its fetch (R12 via pc_load field)
    task automatic run_instr(int c, logic [5:0] f, logic z, int nsteps);
        for (int s = 0; s < nsteps; s++) begin
            opcode = class_opc(c);
            funct  = f;
            zero   = (c == C_BEQ) ? z : logic'((s + int'(z)) % 2);
            #1;
            check_word((c == C_BEQ && s == 2) ? "R8 R12" : req_of(c, s),
                       expect_word(c, s, f, zero));
            @(negedge clk);
        end
    endtask

    task automatic hold_reset(int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            opcode = class_opc(i % 6);
            zero   = 1'b1;
            #1;
            check_word("R1", 18'h0);
            @(negedge clk);
        end
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        hold_reset(3);
        run_instr(C_LW, 6'h00, 1'b0, 5);
        run_instr(C_SW, 6'h00, 1'b1, 4);
        run_instr(C_R,  6'h20, 1'b0, 4);
        run_instr(C_R,  6'h22, 1'b1, 4);
        run_instr(C_R,  6'h24, 1'b0, 4);
        run_instr(C_R,  6'h25, 1'b1, 4);
        run_instr(C_R,  6'h2A, 1'b0, 4);
        run_instr(C_R,  6'h3F, 1'b1, 4);
        run_instr(C_BEQ, 6'h00, 1'b1, 3);
        run_instr(C_BEQ, 6'h00, 1'b0, 3);
        run_instr(C_J,  6'h00, 1'b0, 3);
        run_instr(C_BAD, 6'h00, 1'b1, 2);
        opcode = 6'b000001;
        run_instr(C_J,  6'h00, 1'b1, 3);
        // Reset in the middle of a load, then restart at fetch
        run_instr(C_LW, 6'h00, 1'b0, 3);
        hold_reset(2);
        run_instr(C_LW, 6'h00, 1'b1, 5);
        run_instr(C_SW, 6'h00, 1'b0, 4);
        run_instr(C_BEQ, 6'h00, 1'b1, 3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule